// File: doc/BRIEF.md
# Idle-Jamming Link Framing Controller

This block sits at the transmit front end of a simplified link that does not follow a standard framing protocol. The host has no ordered-set control codes to mix into its data path. It drives a 32-bit word stream and a single idle input. While the idle input is low, each word passes through as user data. When the idle input rises, the block replaces the host's word with an end-of-frame ordered set. As long as the idle input stays high, it then sends idle ordered sets. No start-of-frame delimiter is ever sent: user data begins on the first cycle after the idle input falls.

A CRC-32 accumulator runs over the user data and is reseeded by every ordered set. The preceding idle is therefore enough to start a correct checksum. In generate mode the block inserts the complemented CRC as an extra word ahead of the end-of-frame, so the end-of-frame comes one cycle later. In check mode the last user word is taken to be the CRC of the words before it. An error pulse reports a mismatch in the same cycle as the end-of-frame word. Every output word is tagged as data, CRC, end-of-frame or idle. Line coding of the output is done downstream.

Top module: `idle_jam_framer`

## Requirements
- R1: While reset is high and in the first cycle after it, the output tag is IDLE (code 3), the output word is the idle code (default 32'hBC95B5B5) and the error output is low.
- R2: Output is registered. A word sampled with the idle input low appears on the next cycle with tag DATA (code 0) and the same value. No start-of-frame word is ever emitted.
- R3: In check mode (gen_mode low), the first clock edge at which the idle input is high produces tag EOF (code 2) with the end-of-frame code (default 32'hBCB5F5F5) on the next cycle.
- R4: Each later edge at which the idle input is still high, and at which no end-of-frame is pending, produces tag IDLE with the idle code.
- R5: In generate mode (gen_mode high), the first idle edge produces tag CRC (code 1) carrying the complemented CRC of the frame's data words. The next edge produces tag EOF. Later edges produce IDLE.
- R6: The CRC is the reflected CRC-32 with polynomial 32'hEDB88320 and an initial value of all ones. Each word is fed in bit 0 first. The CRC is reseeded to all ones on every cycle the idle input is high.
- R7: In check mode, the error output pulses high for exactly the cycle of the EOF word when the frame's last data word differs from the complemented CRC of the frame's preceding data words. Otherwise it stays low.
- R8: In generate mode the error output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_mode | input | 1 | 1 = insert CRC, 0 = check CRC carried in user data |
| link_idle | input | 1 | High marks non-data cycles |
| din | input | 32 | Host word |
| dout | output | 32 | Output word |
| dtag | output | 2 | Output word type: 0 data, 1 CRC, 2 EOF, 3 IDLE |
| crc_err | output | 1 | CRC mismatch pulse, aligned with EOF in check mode |

## Verification
The assertions assume that, in generate mode, the idle input stays high for at least two cycles, so that the CRC slot and the end-of-frame both fit. They also assume that the mode changes only while the link is idling. The stimulus sets the mode only during idle gaps of two or more cycles, and each frame carries at least one data word. Random frame lengths, contents and corruption of the trailing CRC word are mixed with directed frames: a one-word frame whose only word is zero, and a generated CRC fed back through check mode.

// File: rtl/idle_jam_pkg.sv
package idle_jam_pkg;
  typedef enum logic [1:0] {
    TAG_DATA = 2'd0,
    TAG_CRC  = 2'd1,
    TAG_EOF  = 2'd2,
    TAG_IDLE = 2'd3
  } tag_t;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_CRC,
    SEL_EOF_CHK,
    SEL_EOF,
    SEL_IDLE
  } sel_t;
endpackage

// File: rtl/idle_jam_crc.sv
module idle_jam_crc #(
  parameter int          DW   = 32,
  parameter logic [31:0] POLY = 32'hEDB88320,
  parameter logic [31:0] SEED = 32'hFFFFFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reseed,
  input  logic          advance,
  input  logic [DW-1:0] word_in,
  output logic [31:0]   crc_now,
  output logic [31:0]   crc_prev,
  output logic [DW-1:0] last_word
);
  function automatic logic [31:0] fold(input logic [31:0] c, input logic [DW-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < DW; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_now   <= SEED;
      crc_prev  <= SEED;
      last_word <= '0;
    end else if (reseed) begin
      crc_now <= SEED;
    end else if (advance) begin
      crc_prev  <= crc_now;
      crc_now   <= fold(crc_now, word_in);
      last_word <= word_in;
    end
  end

  // R6
  seed_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> crc_now == SEED);
endmodule

// File: rtl/idle_jam_seq.sv
module idle_jam_seq
  import idle_jam_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic gen,
  output sel_t sel
);
  logic prev_idle;
  logic crc_slot;

  always_comb begin
    if (!idle)          sel = SEL_DATA;
    else if (!prev_idle) sel = gen ? SEL_CRC : SEL_EOF_CHK;
    else if (crc_slot)  sel = SEL_EOF;
    else                sel = SEL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idle <= 1'b1;
      crc_slot  <= 1'b0;
    end else begin
      prev_idle <= idle;
      crc_slot  <= idle && !prev_idle && gen;
    end
  end

  // R5 (input assumption: idle held across the end-of-frame slot)
  idle_held_for_eof_chk: assert property (@(posedge clk) disable iff (rst)
    crc_slot |-> idle && gen);
endmodule

// File: rtl/idle_jam_framer.sv
module idle_jam_framer
  import idle_jam_pkg::*;
#(
  parameter int          DW        = 32,
  parameter logic [31:0] EOF_CODE  = 32'hBCB5F5F5,
  parameter logic [31:0] IDLE_CODE = 32'hBC95B5B5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_mode,
  input  logic          link_idle,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [1:0]    dtag,
  output logic          crc_err
);
  localparam logic [DW-1:0] EOF_W  = DW'(EOF_CODE);
  localparam logic [DW-1:0] IDLE_W = DW'(IDLE_CODE);

  sel_t          sel;
  logic [31:0]   crc_now, crc_prev;
  logic [DW-1:0] last_word;

  idle_jam_seq u_seq (
    .clk (clk), .rst (rst), .idle (link_idle), .gen (gen_mode), .sel (sel)
  );

  idle_jam_crc #(.DW(DW)) u_crc (
    .clk (clk), .rst (rst), .reseed (link_idle), .advance (!link_idle),
    .word_in (din), .crc_now (crc_now), .crc_prev (crc_prev),
    .last_word (last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= IDLE_W;
      dtag    <= TAG_IDLE;
      crc_err <= 1'b0;
    end else begin
      crc_err <= 1'b0;
      unique case (sel)
        SEL_DATA: begin dout <= din;            dtag <= TAG_DATA; end
        SEL_CRC:  begin dout <= DW'(~crc_now);  dtag <= TAG_CRC;  end
        SEL_EOF_CHK: begin
          dout    <= EOF_W;
          dtag    <= TAG_EOF;
          crc_err <= last_word != DW'(~crc_prev);
        end
        SEL_EOF:  begin dout <= EOF_W;  dtag <= TAG_EOF;  end
        default:  begin dout <= IDLE_W; dtag <= TAG_IDLE; end
      endcase
    end
  end

  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !link_idle |=> dtag == TAG_DATA && dout == $past(din));
  // R5
  crc_then_eof_chk: assert property (@(posedge clk) disable iff (rst)
    dtag == TAG_CRC |=> dtag == TAG_EOF);
  // R8
  crc_slot_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    dtag == TAG_CRC |=> !crc_err);
  // R7
  err_on_eof_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> dtag == TAG_EOF);
  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |=> !crc_err);
  // R4
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (dtag == TAG_EOF && link_idle) |=> dtag == TAG_IDLE);
endmodule

// File: tb/test_idle_jam_framer.sv
module test_idle_jam_framer;
  localparam logic [31:0] EOFC  = 32'hBCB5F5F5;
  localparam logic [31:0] IDLEC = 32'hBC95B5B5;

  logic clk = 1'b0, rst = 1'b1, gen_mode = 1'b0, link_idle = 1'b1;
  logic [31:0] din = '0, dout;
  logic [1:0]  dtag;
  logic        crc_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] fw [16];

  always #2 clk = ~clk;

  idle_jam_framer i_idle_jam_framer (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .link_idle(link_idle),
    .din(din), .dout(dout), .dtag(dtag), .crc_err(crc_err)
  );

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 32; b++) begin
        logic fb = c[0] ^ fw[w][b];
        c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic idle, input logic [31:0] w);
    @(negedge clk);
    link_idle = idle; din = w;
    @(posedge clk); #1;
  endtask

  // n data words already in fw; gap idle cycles follow (>= 2)
  task automatic frame(input logic gen, input int n, input int gap, input logic exp_err);
    logic [31:0] c;
    @(negedge clk); gen_mode = gen;
    for (int i = 0; i < n; i++) begin
      step(1'b0, fw[i]);
      check("R2 tag", 32'(dtag), 32'd0);
      check("R2 word", dout, fw[i]);
    end
    if (gen) begin
      c = ~ref_crc(n);
      step(1'b1, $urandom);
      check("R5 crc tag", 32'(dtag), 32'd1);
      check("R6 crc word", dout, c);
      check("R8 err", 32'(crc_err), 32'd0);
      step(1'b1, $urandom);
      check("R5 eof tag", 32'(dtag), 32'd2);
      check("R5 eof word", dout, EOFC);
      check("R8 err", 32'(crc_err), 32'd0);
      gap--;
    end else begin
      step(1'b1, $urandom);
      check("R3 eof tag", 32'(dtag), 32'd2);
      check("R3 eof word", dout, EOFC);
      check("R7 err", 32'(crc_err), 32'(exp_err));
    end
    for (int i = 1; i < gap; i++) begin
      step(1'b1, $urandom);
      check("R4 idle tag", 32'(dtag), 32'd3);
      check("R4 idle word", dout, IDLEC);
      check("R7 err low", 32'(crc_err), 32'd0);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 tag in reset", 32'(dtag), 32'd3);
    check("R1 word in reset", dout, IDLEC);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 tag after reset", 32'(dtag), 32'd3);
    check("R1 err after reset", 32'(crc_err), 32'd0);

    // directed: one zero word is a valid CRC for an empty payload (R7, R6)
    fw[0] = 32'h0;
    frame(1'b0, 1, 3, 1'b0);
    fw[0] = 32'h1;
    frame(1'b0, 1, 2, 1'b1);

    // directed: generated CRC fed back through check mode
    for (int i = 0; i < 4; i++) fw[i] = 32'h11111111 * (i + 1);
    frame(1'b1, 4, 3, 1'b0);
    fw[4] = ~ref_crc(4);
    frame(1'b0, 5, 2, 1'b0);

    // random frames
    for (int f = 0; f < 60; f++) begin
      int n = 1 + ($urandom % 8);
      logic g = $urandom % 2;
      logic bad = ($urandom % 3) == 0;
      for (int i = 0; i < n; i++) fw[i] = $urandom;
      if (!g) begin
        fw[n-1] = ~ref_crc(n - 1);
        if (bad) fw[n-1] = fw[n-1] ^ (32'h1 << ($urandom % 32));
      end
      frame(g, n, 2 + ($urandom % 4), !g && bad);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule